// File: doc/BRIEF.md
# Pixel Clock Synthesizer Parameter Search

This block turns a requested pixel period, given in picoseconds, into the three settings of a frequency synthesizer: a multiplier k, a divider n and a power-of-two post-shift p. It runs a sequential search. First it clamps the period to a floor and rejects periods that are too long. It then picks the post-shift from the size of the period and forms a working divisor L by shifting the period left by p. For every multiplier from 1 to 31 it divides the product of a fixed reference constant (256016) and k by L. It keeps the candidate with the smallest remainder whose quotient lies in a usable range.

The block has a shared restoring divider that produces one quotient bit per clock. A search therefore takes several hundred cycles. The controlling logic raises a single `start` pulse and then waits for the one-cycle `done` pulse. While the search runs, `busy` is high and further start pulses are dropped. The control pins are plain levels and pulses: there is no back-pressure, and the result registers simply hold between runs.

Top module: `pixclk_param_search`

## Requirements
- R1: A requested period below 5000 ps is treated exactly as 5000 ps, so any such request gives the same k, n, p and error as a request of 5000.
- R2: A period (after the floor of R1) above 2048128 ps is rejected. `done` rises within 4 clock cycles of the accepted start, `error` is 1, and k, n and p are all 0.
- R3: The post-shift p is 3 when the period multiplied by 16 is below 256016, and 2 otherwise. The working divisor L is the period multiplied by 2^p.
- R4: For k = 1..31 in increasing order, with M = 256016·k, N = M / L and R = M mod L, a candidate is taken only when 1 <= N <= 127 and R is strictly below the best remainder so far. The best remainder starts at L. The reported k and n are those of the last candidate taken, so on equal remainders the lowest k wins.
- R5: When no candidate is taken, `error` is 1 and k, n and p are reported as 0. On success `error` is 0 and n is nonzero.
- R6: `busy` rises at the clock edge that accepts `start` and falls at the edge that raises `done`. `done` is high for exactly one cycle.
- R7: A `start` that arrives while `busy` is high is ignored: the running search completes with the result for the original period, and no second `done` follows.
- R8: The outputs `mult_k`, `div_n`, `post_shift` and `error` change only at the edge that raises `done`, and hold their values until the next search completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a search; taken only when idle |
| period_ps | input | 22 | Requested pixel period in picoseconds |
| busy | output | 1 | High while a search is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| mult_k | output | 5 | Chosen multiplier k (0 on error) |
| div_n | output | 7 | Chosen divider n (0 on error) |
| post_shift | output | 2 | Chosen post-shift p (0 on error) |
| error | output | 1 | High when the request was rejected or had no candidate |

## Verification
The bench targets these edges:
- Both sides of the post-shift threshold (16000 and 16001). A design with the comparison reversed or off by one reports the wrong p and a different k/n.
- A period whose divisor divides the reference exactly, so k=1 and k=2 both give a zero remainder. A non-strict comparison would drift to a higher k.
- Both error routes: the longest legal period and the first period above it. One yields an empty search and the other must be rejected within a few cycles, so a design that merges or mislabels them shows the wrong latency or a stale result.
- A second start sent mid-search, and the quiet period after done. A design that restarts or lets its results wander would show a changed triple or an extra done pulse.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_ISSUE,
    S_WAIT,
    S_EVAL,
    S_FIN
  } srch_state_t;
endpackage

// File: rtl/pcs_divider.sv
module pcs_divider #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]    acc;
  logic [W-1:0]    qr;
  logic [W-1:0]    dsr;
  logic [CNTW-1:0] cnt;
  logic            done_q;
  logic [W:0]      trial;
  logic            ge;

  assign trial = {acc, qr[W-1]};
  assign ge    = trial >= {1'b0, dsr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      qr     <= '0;
      dsr    <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        acc <= '0;
        qr  <= dividend_i;
        dsr <= divisor_i;
        cnt <= CNTW'(W);
      end else if (cnt != '0) begin
        acc    <= ge ? W'(trial - {1'b0, dsr}) : trial[W-1:0];
        qr     <= {qr[W-2:0], ge};
        cnt    <= cnt - 1'b1;
        done_q <= (cnt == CNTW'(1));
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = qr;
  assign rem_o  = acc;

  // R4
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (acc < dsr));

  // R4
  no_restart_mid_divide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (cnt == '0));
endmodule

// File: rtl/pcs_search.sv
module pcs_search
  import pcs_pkg::*;
#(
  parameter int REF   = 256016,
  parameter int PMIN  = 5000,
  parameter int KMAX  = 31,
  parameter int NLIM  = 128,
  parameter int PER_W = 22,
  parameter int CW    = 23,
  parameter int KW    = 5,
  parameter int NW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PER_W-1:0] period_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [KW-1:0]    k_o,
  output logic [NW-1:0]    n_o,
  output logic [1:0]       p_o,
  output logic             err_o,
  output logic             div_start_o,
  output logic [CW-1:0]    div_dividend_o,
  output logic [CW-1:0]    div_divisor_o,
  input  logic             div_done_i,
  input  logic [CW-1:0]    div_quot_i,
  input  logic [CW-1:0]    div_rem_i
);
  localparam int LIMIT = REF * 8;
  localparam int EW    = PER_W + 5;

  srch_state_t      state;
  logic [PER_W-1:0] per_q;
  logic [CW-1:0]    l_q, m_q, best_q;
  logic [KW-1:0]    k_q, bk_q;
  logic [NW-1:0]    bn_q;
  logic [1:0]       p_q;
  logic             found_q;
  logic [EW-1:0]    per_ext;
  logic [1:0]       p_sel;
  logic             accept;

  assign per_ext = EW'(per_q);
  assign p_sel   = ((per_ext << 4) < EW'(REF)) ? 2'd3 : 2'd2;
  assign accept  = (div_quot_i != '0) && (div_quot_i < CW'(NLIM)) && (div_rem_i < best_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      per_q   <= '0;
      l_q     <= '0;
      m_q     <= '0;
      best_q  <= '0;
      k_q     <= '0;
      bk_q    <= '0;
      bn_q    <= '0;
      p_q     <= '0;
      found_q <= 1'b0;
      done_o  <= 1'b0;
      k_o     <= '0;
      n_o     <= '0;
      p_o     <= '0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i) begin
          per_q <= (period_i < PER_W'(PMIN)) ? PER_W'(PMIN) : period_i;
          state <= S_CHECK;
        end
        S_CHECK: begin
          if (per_ext > EW'(LIMIT)) begin
            k_o    <= '0;
            n_o    <= '0;
            p_o    <= '0;
            err_o  <= 1'b1;
            done_o <= 1'b1;
            state  <= S_IDLE;
          end else begin
            p_q     <= p_sel;
            l_q     <= CW'(per_ext << p_sel);
            best_q  <= CW'(per_ext << p_sel);
            m_q     <= CW'(REF);
            k_q     <= KW'(1);
            bk_q    <= '0;
            bn_q    <= '0;
            found_q <= 1'b0;
            state   <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT:  if (div_done_i) state <= S_EVAL;
        S_EVAL: begin
          if (accept) begin
            best_q  <= div_rem_i;
            bk_q    <= k_q;
            bn_q    <= div_quot_i[NW-1:0];
            found_q <= 1'b1;
          end
          if (k_q == KW'(KMAX)) begin
            state <= S_FIN;
          end else begin
            k_q   <= k_q + 1'b1;
            m_q   <= m_q + CW'(REF);
            state <= S_ISSUE;
          end
        end
        S_FIN: begin
          k_o    <= found_q ? bk_q : '0;
          n_o    <= found_q ? bn_q : '0;
          p_o    <= found_q ? p_q : 2'd0;
          err_o  <= !found_q;
          done_o <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o         = (state != S_IDLE);
  assign div_start_o    = (state == S_ISSUE);
  assign div_dividend_o = m_q;
  assign div_divisor_o  = l_q;

  // R6
  busy_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(k_o) && $stable(n_o) && $stable(p_o) && $stable(err_o)));

  // R5
  success_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> ((n_o != '0) && (k_o != '0) && (p_o >= 2'd2)));

  // R2
  error_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> ((k_o == '0) && (n_o == '0) && (p_o == 2'd0)));
endmodule

// File: rtl/pixclk_param_search.sv
module pixclk_param_search #(
  parameter int REF   = 256016,
  parameter int PMIN  = 5000,
  parameter int KMAX  = 31,
  parameter int NLIM  = 128,
  parameter int PER_W = 22
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [PER_W-1:0]           period_ps,
  output logic                       busy,
  output logic                       done,
  output logic [$clog2(KMAX+1)-1:0]  mult_k,
  output logic [$clog2(NLIM)-1:0]    div_n,
  output logic [1:0]                 post_shift,
  output logic                       error
);
  localparam int CW = $clog2((REF << 5) + 1);
  localparam int KW = $clog2(KMAX + 1);
  localparam int NW = $clog2(NLIM);

  logic          div_start, div_done;
  logic [CW-1:0] div_dividend, div_divisor, div_quot, div_rem;

  pcs_search #(
    .REF(REF), .PMIN(PMIN), .KMAX(KMAX), .NLIM(NLIM),
    .PER_W(PER_W), .CW(CW), .KW(KW), .NW(NW)
  ) u_search (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .period_i       (period_ps),
    .busy_o         (busy),
    .done_o         (done),
    .k_o            (mult_k),
    .n_o            (div_n),
    .p_o            (post_shift),
    .err_o          (error),
    .div_start_o    (div_start),
    .div_dividend_o (div_dividend),
    .div_divisor_o  (div_divisor),
    .div_done_i     (div_done),
    .div_quot_i     (div_quot),
    .div_rem_i      (div_rem)
  );

  pcs_divider #(.W(CW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (div_dividend),
    .divisor_i  (div_divisor),
    .done_o     (div_done),
    .quot_o     (div_quot),
    .rem_o      (div_rem)
  );
endmodule

// File: tb/pixclk_param_search_test.sv
module pixclk_param_search_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [21:0] period_ps = '0;
  logic        busy, done, error;
  logic [4:0]  mult_k;
  logic [6:0]  div_n;
  logic [1:0]  post_shift;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pixclk_param_search uut (
    .clk(clk), .rst_n(rst_n), .start(start), .period_ps(period_ps),
    .busy(busy), .done(done), .mult_k(mult_k), .div_n(div_n),
    .post_shift(post_shift), .error(error)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input longint per_in, output int ek, output int en,
                                output int ep, output int ee);
    longint per, l, best, m, n, r;
    per = (per_in < 5000) ? 5000 : per_in;
    ek = 0; en = 0; ep = 0; ee = 1;
    if (per > 256016 * 8) return;
    ep = ((per * 16) < 256016) ? 3 : 2;
    l = per << ep;
    best = l;
    for (int k = 1; k <= 31; k++) begin
      m = 256016 * k;
      n = m / l;
      r = m % l;
      if (n != 0 && n < 128 && r < best) begin
        ek = k; en = int'(n); best = r;
      end
    end
    if (ek == 0) begin ep = 0; ee = 1; end else ee = 0;
  endfunction

  task automatic launch(input longint per);
    @(negedge clk);
    period_ps = 22'(per);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic expect_result(input string req, input longint per);
    int ek, en, ep, ee;
    model(per, ek, en, ep, ee);
    chk({req, " done"}, done, 1);
    chk({req, " k"}, mult_k, ek);
    chk({req, " n"}, div_n, en);
    chk({req, " p"}, post_shift, ep);
    chk({req, " error"}, error, ee);
  endtask

  task automatic run_and_check(input string req, input longint per);
    int lat;
    launch(per);
    wait_done(lat);
    expect_result(req, per);
  endtask

  task automatic t_reset();
    chk("reset busy", busy, 0);
    chk("reset done", done, 0);
    chk("reset error", error, 0);
    chk("reset k", mult_k, 0);
    chk("reset n", div_n, 0);
    chk("reset p", post_shift, 0);
  endtask

  // R1: values below the floor behave as 5000
  task automatic t_floor();
    run_and_check("R1 at floor", 5000);
    run_and_check("R1 zero", 0);
    run_and_check("R1 4999", 4999);
  endtask

  // R2: over-long period rejected quickly; R5: longest legal period has no candidate
  task automatic t_range();
    int lat;
    launch(2048129);
    wait_done(lat);
    chk("R2 latency ok", (lat <= 4) ? 1 : 0, 1);
    expect_result("R2 reject", 2048129);
    chk("R2 error", error, 1);
    launch(2048128);
    wait_done(lat);
    chk("R5 full search ran", (lat > 100) ? 1 : 0, 1);
    expect_result("R5 no candidate", 2048128);
    chk("R5 error", error, 1);
  endtask

  // R3: post-shift threshold
  task automatic t_shift();
    run_and_check("R3 below", 16000);
    chk("R3 p3", post_shift, 3);
    run_and_check("R3 above", 16001);
    chk("R3 p2", post_shift, 2);
  endtask

  // R4: exact tie keeps lowest k; spread of ordinary periods
  task automatic t_search();
    run_and_check("R4 tie", 16001);
    chk("R4 tie k", mult_k, 1);
    chk("R4 tie n", div_n, 4);
    run_and_check("R4 typical", 39721);
    run_and_check("R4 mid", 10000);
    run_and_check("R4 slow", 100000);
    run_and_check("R4 very slow", 1000000);
  endtask

  // R6 and R7: busy timing, start ignored while busy
  task automatic t_busy();
    int lat, extra;
    launch(39721);
    chk("R6 busy after start", busy, 1);
    chk("R6 no early done", done, 0);
    repeat (100) @(negedge clk);
    chk("R6 busy mid", busy, 1);
    period_ps = 22'd7777;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    period_ps = 22'd0;
    wait_done(lat);
    chk("R6 busy low at done", busy, 0);
    expect_result("R7 original result", 39721);
    extra = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    chk("R7 no second run", extra, 0);
  endtask

  // R8: outputs hold after done
  task automatic t_hold();
    int ek, en, ep, ee, bad;
    run_and_check("R8 setup", 25000);
    model(25000, ek, en, ep, ee);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      period_ps = 22'(i * 1000);
      if (mult_k != ek || div_n != en || post_shift != ep || error != ee) bad++;
    end
    chk("R8 hold", bad, 0);
    chk("R6 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_floor();
    t_range();
    t_shift();
    t_search();
    t_busy();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule